// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block picks the multiplier and divider settings for a clock synthesizer so that its output comes as close as possible to a requested pixel frequency. The synthesizer is fed from a fixed 13000 kHz reference. For a multiplier M, a pre-divider N and a power-of-two post-divider P, its output is the reference times M, divided by N times two to the power P, with the division truncated.

The requester applies a target frequency in kHz and pulses `start`. The engine then tries every legal combination in a fixed order. M is the outermost loop, N is the middle loop and P is the innermost loop. For each candidate it works out the truncated output frequency and keeps the candidate with the smallest absolute error. At the end it presents the chosen M, N and P and the frequency they produce, and it raises `done` for one cycle.

Each (M, N) pair needs one division, which a restoring divider performs at several quotient bits per cycle. The eight values of P then come from right shifts of that one quotient.

Top module: `clk_div_search`

## Requirements
- R1: When `done` is high, `best_freq` equals floor(13000 × `best_m` / (`best_n` × 2^`best_p`)).
- R2: Only M in 1..63, N in 2..7 and P in 0..7 are tried, so a reported N is never 0 or 1 and a reported M is never 0.
- R3: The reported candidate has the smallest absolute error |frequency − target| among all legal candidates.
- R4: When several candidates share the smallest error, the engine reports the one reached first in the order M ascending (outermost), then N ascending, then P ascending (innermost).
- R5: A `start` pulse seen while idle latches `target_khz`, and `busy` is high in the cycle after that pulse.
- R6: A `start` pulse seen while `busy` is high is ignored, along with the `target_khz` value that comes with it. The running search completes for the target latched at its own start.
- R7: `done` is high for exactly one cycle. In that cycle `busy` is low and the four result outputs already hold the final result.
- R8: While `busy` is low, the result outputs do not change.
- R9: After reset, `busy` and `done` are low and every result output is zero.
- R10: `done` arrives no more than 6000 cycles after the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; ignored while busy |
| target_khz | input | 32 | Requested frequency in kHz, sampled with start |
| busy | output | 1 | High while a search is running |
| done | output | 1 | One-cycle pulse when the result is final |
| best_m | output | 6 | Chosen multiplier M |
| best_n | output | 3 | Chosen pre-divider N |
| best_p | output | 3 | Chosen post-divider exponent P |
| best_freq | output | 32 | Frequency in kHz produced by the chosen settings |

## Verification
The only result whose cycle is fixed is `busy`, which must be high one cycle after an accepted `start`. The bench samples it at the first falling edge after that start. The search result is due in the cycle `done` is high. The bench waits for that pulse falling edge by falling edge, with a limit of 6000 cycles. It compares all four outputs against a bench model at that falling edge. One cycle later it checks that `done` has dropped. After twenty idle cycles it checks that the held outputs have not moved.

// File: rtl/clk_search_pkg.sv
package clk_search_pkg;
  localparam int REF_KHZ = 13000;
  localparam int M_MIN = 1;
  localparam int M_MAX = 63;
  localparam int N_MIN = 2;
  localparam int N_MAX = 7;
  localparam int P_MAX = 7;
  localparam int M_W = $clog2(M_MAX + 1);
  localparam int N_W = $clog2(N_MAX + 1);
  localparam int P_W = $clog2(P_MAX + 1);
  localparam int F_W = 32;
  localparam int NUM_W = $clog2(REF_KHZ * M_MAX + 1);

  // strobes and loop indices from control to datapath
  typedef struct packed {
    logic           load;
    logic           divGo;
    logic           eval;
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
    logic [P_W-1:0] p;
  } ctrl_t;
endpackage

// File: rtl/clk_search_div.sv
module clk_search_div #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 3,
  parameter int STEPS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int ROUNDS = (NUM_W + STEPS - 1) / STEPS;
  localparam int PAD_W  = ROUNDS * STEPS;
  localparam int CNT_W  = $clog2(ROUNDS + 1);

  logic [DEN_W-1:0] remR, remV, denR;
  logic [PAD_W-1:0] quoR, quoV;
  logic [CNT_W-1:0] cntR;
  logic             doneR;

  // STEPS restoring iterations per clock
  always_comb begin
    logic [DEN_W:0] trial;
    remV = remR;
    quoV = quoR;
    for (int i = 0; i < STEPS; i++) begin
      trial = {remV, quoV[PAD_W-1]};
      quoV  = quoV << 1;
      if (trial >= {1'b0, denR}) begin
        trial   = trial - {1'b0, denR};
        quoV[0] = 1'b1;
      end
      remV = trial[DEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      denR  <= '0;
      cntR  <= '0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (go) begin
        remR <= '0;
        quoR <= PAD_W'(num);
        denR <= den;
        cntR <= CNT_W'(ROUNDS);
      end else if (cntR != '0) begin
        remR <= remV;
        quoR <= quoV;
        cntR <= cntR - 1'b1;
        if (cntR == CNT_W'(1)) doneR <= 1'b1;
      end
    end
  end

  assign quo  = quoR[NUM_W-1:0];
  assign done = doneR;
endmodule

// File: rtl/clk_search_ctrl.sv
module clk_search_ctrl
  import clk_search_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  divDone,
  output ctrl_t ctl,
  output logic  busy,
  output logic  done
);
  typedef enum logic [1:0] {S_IDLE, S_DIV, S_SCAN, S_LAUNCH} state_t;

  state_t         stateR;
  logic [M_W-1:0] mR;
  logic [N_W-1:0] nR;
  logic [P_W-1:0] pR;
  logic           doneR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= S_IDLE;
      mR     <= M_W'(M_MIN);
      nR     <= N_W'(N_MIN);
      pR     <= '0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      unique case (stateR)
        S_IDLE:   if (start) stateR <= S_DIV;
        S_DIV:    if (divDone) begin
                    stateR <= S_SCAN;
                    pR     <= '0;
                  end
        S_SCAN: begin
          pR <= pR + 1'b1;
          if (pR == P_W'(P_MAX)) begin
            if (nR == N_W'(N_MAX)) begin
              nR <= N_W'(N_MIN);
              if (mR == M_W'(M_MAX)) begin
                mR     <= M_W'(M_MIN);
                stateR <= S_IDLE;
                doneR  <= 1'b1;
              end else begin
                mR     <= mR + 1'b1;
                stateR <= S_LAUNCH;
              end
            end else begin
              nR     <= nR + 1'b1;
              stateR <= S_LAUNCH;
            end
          end
        end
        S_LAUNCH: stateR <= S_DIV;
        default:  stateR <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load  = (stateR == S_IDLE) && start;
    ctl.divGo = ((stateR == S_IDLE) && start) || (stateR == S_LAUNCH);
    ctl.eval  = (stateR == S_SCAN);
    ctl.m     = mR;
    ctl.n     = nR;
    ctl.p     = pR;
  end

  assign busy = (stateR != S_IDLE);
  assign done = doneR;
endmodule

// File: rtl/clk_search_dp.sv
module clk_search_dp
  import clk_search_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrl_t          ctl,
  input  logic [F_W-1:0] target,
  output logic           divDone,
  output logic [M_W-1:0] bestM,
  output logic [N_W-1:0] bestN,
  output logic [P_W-1:0] bestP,
  output logic [F_W-1:0] bestFreq
);
  logic [F_W-1:0]   targetR, bestErrR, cand, err;
  logic [NUM_W-1:0] num, quo;

  assign num = NUM_W'(ctl.m) * NUM_W'(REF_KHZ);

  clk_search_div #(.NUM_W(NUM_W), .DEN_W(N_W), .STEPS(STEPS)) u_div (
    .clk(clk), .rstN(rstN), .go(ctl.divGo), .num(num), .den(ctl.n),
    .quo(quo), .done(divDone)
  );

  // floor(floor(a/n)/2^p) == floor(a/(n*2^p))
  assign cand = F_W'(quo >> ctl.p);
  assign err  = (cand > targetR) ? (cand - targetR) : (targetR - cand);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetR  <= '0;
      bestErrR <= '1;
      bestM    <= '0;
      bestN    <= '0;
      bestP    <= '0;
      bestFreq <= '0;
    end else if (ctl.load) begin
      targetR  <= target;
      bestErrR <= '1;
    end else if (ctl.eval && (err < bestErrR)) begin
      bestErrR <= err;
      bestM    <= ctl.m;
      bestN    <= ctl.n;
      bestP    <= ctl.p;
      bestFreq <= cand;
    end
  end
endmodule

// File: rtl/clk_div_search.sv
module clk_div_search
  import clk_search_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] target_khz,
  output logic        busy,
  output logic        done,
  output logic [5:0]  best_m,
  output logic [2:0]  best_n,
  output logic [2:0]  best_p,
  output logic [31:0] best_freq
);
  ctrl_t ctl;
  logic  divDone;

  clk_search_ctrl u_ctrl (
    .clk(clk), .rstN(rst_n), .start(start), .divDone(divDone),
    .ctl(ctl), .busy(busy), .done(done)
  );

  clk_search_dp #(.STEPS(STEPS)) u_dp (
    .clk(clk), .rstN(rst_n), .ctl(ctl), .target(target_khz),
    .divDone(divDone), .bestM(best_m), .bestN(best_n), .bestP(best_p),
    .bestFreq(best_freq)
  );
endmodule

// File: rtl/clk_div_search_chk.sv
module clk_div_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [5:0]  best_m,
  input logic [2:0]  best_n,
  input logic [2:0]  best_p,
  input logic [31:0] best_freq
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({best_m, best_n, best_p, best_freq}));

  assert_legal_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_m != 6'd0) && (best_n >= 3'd2));

  assert_busy_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_freq_formula_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> best_freq == ((32'd13000 * 32'(best_m)) / (32'(best_n) << best_p)));
endmodule

bind clk_div_search clk_div_search_chk u_chk (.*);

// File: tb/sim_clk_div_search.sv
module sim_clk_div_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] target_khz = '0;
  logic        busy, done;
  logic [5:0]  best_m;
  logic [2:0]  best_n, best_p;
  logic [31:0] best_freq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clk_div_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .busy(busy), .done(done), .best_m(best_m), .best_n(best_n),
    .best_p(best_p), .best_freq(best_freq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // exhaustive model: M outer, N middle, P inner, strict improvement only
  task automatic model(input longint tgt, output int om, output int on,
                       output int op, output longint of);
    longint bestErr = 64'h7fffffffffffffff;
    om = 0; on = 0; op = 0; of = 0;
    for (int m = 1; m <= 63; m++)
      for (int n = 2; n <= 7; n++)
        for (int p = 0; p <= 7; p++) begin
          longint f = (longint'(13000) * m) / (longint'(n) << p);
          longint e = (f > tgt) ? f - tgt : tgt - f;
          if (e < bestErr) begin
            bestErr = e; om = m; on = n; op = p; of = f;
          end
        end
  endtask

  task automatic search(input logic [31:0] tgt, input bit intrude,
                        input string req);
    int em, en, ep, cnt;
    longint ef;
    logic [43:0] held;
    model(longint'(tgt), em, en, ep, ef);
    @(negedge clk);
    target_khz = tgt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    target_khz = 32'd1;
    chk(busy === 1'b1, "R5", "busy after start", longint'(busy), 1);
    if (intrude) begin
      repeat (100) @(negedge clk);
      target_khz = 32'd400000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cnt = 0;
    while (done !== 1'b1 && cnt < 6000) begin
      @(negedge clk);
      cnt++;
    end
    chk(done === 1'b1, "R10", "done within limit", longint'(cnt), 6000);
    chk(best_m == em && best_n == en && best_p == ep, req, "M*64+N*8+P",
        longint'(best_m) * 64 + best_n * 8 + best_p, longint'(em) * 64 + en * 8 + ep);
    chk(best_freq == ef, "R1", "best_freq", longint'(best_freq), ef);
    chk(busy === 1'b0, "R7", "busy at done", longint'(busy), 0);
    held = {best_m, best_n, best_p, best_freq};
    @(negedge clk);
    chk(done === 1'b0, "R7", "done one cycle", longint'(done), 0);
    repeat (20) @(negedge clk);
    chk({best_m, best_n, best_p, best_freq} == held, "R8", "held result",
        longint'(best_freq), longint'(held[31:0]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy === 1'b0 && done === 1'b0, "R9", "busy/done in reset",
        longint'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({best_m, best_n, best_p, best_freq} == '0, "R9", "result after reset",
        longint'(best_freq), 0);
    search(32'd25000, 1'b0, "R3");
    search(32'd13000, 1'b0, "R4");      // first exact hit is M=2,N=2,P=0
    search(32'd0, 1'b0, "R2");          // smallest output, M=1,N=7,P=7
    search(32'hFFFF_FFFF, 1'b0, "R2");  // largest output, M=63,N=2,P=0
    search(32'd31500, 1'b1, "R6");      // late start ignored
    for (int i = 0; i < 6; i++)
      search($urandom_range(420000, 1000), 1'b0, "R3");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule